// File: doc/BRIEF.md
# Addressed MDIO Management Command Engine

This block lets a host reach registers inside an external PHY over a two-wire management bus (clock MDC, bidirectional data MDIO) using the addressed, two-frame access method. Each PHY register access takes two host commands. The first is an address command, which sends the 16-bit register number to a chosen port and device. The second is a write or read command that carries the same port and device fields. The host starts each command by writing a command register with its go bit set. It then polls that bit, which the engine clears when the serial frame ends.

A write takes its 16-bit payload from the lower half of a data register, so the host loads that half before it issues the command pair. A read releases MDIO at the turnaround, shifts in 16 bits from the PHY and places them in the upper half of the same data register. MDC is divided down from the system clock by a parameter. It is low whenever the engine is idle.

Top module: `mdio_cmd_engine`

## Requirements
- R1: During and after reset, the command readback is 0, the data readback is 0, MDC is low, the output enable is low and the MDIO output idles at 1.
- R2: A command write whose bit 30 (go) is 1 and whose opcode field, bits 27:26, is not 2'b10 starts a frame when the engine is idle. The command readback then holds reg bits 15:0, device bits 20:16, port bits 25:21 and opcode bits 27:26. Bit 30 reads 1 until the frame ends.
- R3: A frame is 64 bits sent MSB first. It consists of 32 ones, 2'b00, the opcode (00 address, 01 write, 11 read), the 5-bit port, the 5-bit device, 2'b10 and a 16-bit payload. The payload is the reg field for an address frame and data register bits 15:0 for a write frame.
- R4: MDC stays low while idle. While busy it is high for MDC_HALF system clocks and low for MDC_HALF system clocks. A driven MDIO value changes only as MDC falls.
- R5: In a read frame the output enable drops from bit 46 (the turnaround) to the end of the frame. MDIO is sampled on rising MDC for bits 48 to 63, MSB first. The result lands in data register bits 31:16 when the frame ends, and bits 15:0 are left unchanged.
- R6: Bit 30 clears, together with the last falling MDC, exactly 128*MDC_HALF system clocks after the accepting edge. At the default settings this is far inside 64 us.
- R7: A command write that arrives while a frame is in progress changes neither the command readback nor the frame on the wire, and it does not start another frame.
- R8: A command write with go equal to 0, or with opcode 2'b10, while idle, leaves the command readback unchanged and starts no frame.
- R9: Address and write frames leave data register bits 31:16 holding the last read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command write value |
| cmd_rdata_o | output | 32 | Command readback, bit 30 busy |
| dat_we_i | input | 1 | Data register (lower half) write strobe |
| dat_wdata_i | input | 16 | Write payload |
| dat_rdata_o | output | 32 | Read result in 31:16, write payload in 15:0 |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output to pad |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The bench models the PHY. It rebuilds every expected frame bit, along with the expected enable mask, from the requirements. It targets read frames whose data starts and ends with a 1, so an off-by-one capture window would shift or lose the MSB or LSB, and an engine that held MDIO during the turnaround would show up in the enable mask. It issues commands in the middle of a frame, with a reserved opcode, and without the go bit. A design that accepted any of these would change the readback or put a second frame on the bus. It also measures the exact busy length and the MDC phase widths, so a divider that is off by one cycle fails.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W  = 16;
  localparam int DEV_W  = 5;
  localparam int PORT_W = 5;
  localparam int GO_BIT = 30;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RSVD  = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  // field order sets the command register layout: op 27:26, port 25:21, dev 20:16, reg 15:0
  typedef struct packed {
    mdio_op_e            op;
    logic [PORT_W-1:0]   port;
    logic [DEV_W-1:0]    dev;
    logic [REG_W-1:0]    regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(MDC_HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap &&  mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int PRE_BITS = 32,
  localparam int FB      = PRE_BITS + 32,
  localparam int IW      = $clog2(FB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FB-1:0] frame_i,
  input  logic          read_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          active_o,
  output logic          done_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic [IW-1:0] bit_idx_o,
  output logic [15:0]   cap_o
);
  localparam int REL_IDX = PRE_BITS + 14;  // turnaround
  localparam int CAP_IDX = PRE_BITS + 16;  // first data bit

  logic          active_q, rd_q;
  logic [IW-1:0] idx_q;
  logic [FB-1:0] sh_q;
  logic [15:0]   cap_q;
  logic          last;

  assign last      = (idx_q == IW'(FB - 1));
  assign done_o    = active_q && fall_i && last;
  assign active_o  = active_q;
  assign mdio_o    = active_q ? sh_q[FB-1] : 1'b1;
  assign mdio_oe_o = active_q && !(rd_q && (idx_q >= IW'(REL_IDX)));
  assign bit_idx_o = idx_q;
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '1;
      cap_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      rd_q     <= read_i;
      idx_q    <= '0;
      sh_q     <= frame_i;
      cap_q    <= '0;
    end else if (active_q) begin
      if (rise_i && rd_q && (idx_q >= IW'(CAP_IDX)))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          active_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IW'(1);
          sh_q  <= {sh_q[FB-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  localparam int FB      = PRE_BITS + 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [31:0]   cmd_wdata_i,
  input  logic          dat_we_i,
  input  logic [15:0]   dat_wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [15:0]   cap_i,
  output logic          start_o,
  output logic [FB-1:0] frame_o,
  output logic          read_o,
  output logic [31:0]   cmd_rdata_o,
  output logic [31:0]   dat_rdata_o
);
  mdio_cmd_t   cmd_q, new_cmd;
  logic [15:0] wr_q, rd_q;
  logic [15:0] payload;
  logic        unused_bits;

  assign unused_bits = ^{cmd_wdata_i[31], cmd_wdata_i[29:28]};
  assign new_cmd     = mdio_cmd_t'(cmd_wdata_i[27:0]);
  assign start_o     = cmd_we_i && !busy_i && cmd_wdata_i[GO_BIT] && (new_cmd.op != OP_RSVD);
  assign read_o      = (new_cmd.op == OP_READ);

  always_comb begin
    unique case (new_cmd.op)
      OP_ADDR:  payload = new_cmd.regad;
      OP_WRITE: payload = wr_q;
      default:  payload = '1;
    endcase
  end

  assign frame_o     = {{PRE_BITS{1'b1}}, 2'b00, new_cmd.op, new_cmd.port, new_cmd.dev, 2'b10, payload};
  assign cmd_rdata_o = {1'b0, busy_i, 2'b00, cmd_q};
  assign dat_rdata_o = {rd_q, wr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (start_o)  cmd_q <= new_cmd;
      if (dat_we_i) wr_q  <= dat_wdata_i;
      if (done_i && (cmd_q.op == OP_READ)) rd_q <= cap_i;
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
  parameter int MDC_HALF = 2,
  parameter int PRE_BITS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  input  logic        dat_we_i,
  input  logic [15:0] dat_wdata_i,
  output logic [31:0] dat_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int FB    = PRE_BITS + 32;
  localparam int IDX_W = $clog2(FB);

  logic             start, read, active, done, rise, fall;
  logic [FB-1:0]    frame;
  logic [15:0]      cap;
  logic [IDX_W-1:0] bit_idx;

  mdio_host_regs #(.PRE_BITS(PRE_BITS)) u_regs (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_wdata_i, .dat_we_i, .dat_wdata_i,
    .busy_i(active), .done_i(done), .cap_i(cap),
    .start_o(start), .frame_o(frame), .read_o(read),
    .cmd_rdata_o, .dat_rdata_o
  );

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk_i, .rst_ni, .run_i(active), .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .frame_i(frame), .read_i(read),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .active_o(active), .done_o(done), .mdio_o, .mdio_oe_o,
    .bit_idx_o(bit_idx), .cap_o(cap)
  );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
  parameter int IW      = 6,
  parameter int REL_IDX = 46
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          mdc_i,
  input logic          mdio_q_i,
  input logic          mdio_oe_i,
  input logic [29:0]   cmd_i,
  input logic [IW-1:0] bit_idx_i
);
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i)); // R4

  AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_i && $past(mdio_oe_i) && !$stable(mdio_q_i)) |-> $fell(mdc_i)); // R4

  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (cmd_i[27:26] == 2'b11) && (bit_idx_i >= IW'(REL_IDX))) |-> !mdio_oe_i); // R5

  AST_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cmd_i)); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $fell(mdc_i)); // R6
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.IW(IDX_W), .REL_IDX(PRE_BITS + 14)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(active), .mdc_i(mdc_o),
  .mdio_q_i(mdio_o), .mdio_oe_i(mdio_oe_o), .cmd_i(cmd_rdata_o[29:0]),
  .bit_idx_i(bit_idx)
);

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
  localparam int HALF  = 2;
  localparam int FCYC  = 64 * 2 * HALF;
  localparam int TCLK  = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_we = 1'b0, dat_we = 1'b0, mdio_in = 1'b1;
  logic [31:0] cmd_wdata = '0, cmd_rdata, dat_rdata;
  logic [15:0] dat_wdata = '0;
  logic        mdc, mdio_out, mdio_oe;

  int n_chk = 0, n_bad = 0;
  int cnt = 0;
  logic [63:0] got_bits, got_oe;
  logic [15:0] phy_rd = '0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(HALF), .PRE_BITS(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .cmd_rdata_o(cmd_rdata), .dat_we_i(dat_we), .dat_wdata_i(dat_wdata),
    .dat_rdata_o(dat_rdata), .mdc_o(mdc), .mdio_i(mdio_in), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe)
  );

  // PHY model: record each bit at rising MDC, present read data for the next bit
  always @(posedge mdc) begin
    if (cnt < 64) begin
      got_bits[63-cnt] = mdio_oe ? mdio_out : 1'b0;
      got_oe[63-cnt]   = mdio_oe;
    end
    cnt = cnt + 1;
    if (cnt >= 48 && cnt <= 63) mdio_in = phy_rd[63-cnt];
    else                        mdio_in = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic host_cmd(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                          input logic [15:0] ra, input bit go);
    @(negedge clk);
    cmd_wdata = {1'b0, go, 2'b00, op, port, dev, ra};
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we    = 1'b0;
  endtask

  task automatic load_data(input logic [15:0] d);
    @(negedge clk);
    dat_wdata = d; dat_we = 1'b1;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (cmd_rdata[30]) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                             input logic [15:0] payload);
    logic [63:0] eb, eo;
    eb = {32'hFFFF_FFFF, 2'b00, op, port, dev, 2'b10, payload};
    eo = (op == 2'b11) ? (~64'h0 << 18) : ~64'h0;
    chk(cnt == 64, "R3", "bit count", 64'(cnt), 64'd64);
    chk((got_bits & eo) == (eb & eo), "R3", "frame bits", got_bits & eo, eb & eo);
    chk(got_oe == eo, "R5", "enable mask", got_oe, eo);
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                           input logic [15:0] ra, input logic [15:0] payload);
    int cyc;
    cnt = 0;
    host_cmd(op, port, dev, ra, 1'b1);
    chk(cmd_rdata[30] == 1'b1, "R2", "busy after accept", 64'(cmd_rdata[30]), 64'd1);
    chk(cmd_rdata[27:0] == {op, port, dev, ra}, "R2", "cmd readback",
        64'(cmd_rdata[27:0]), 64'({op, port, dev, ra}));
    wait_idle(cyc);
    chk(cyc == FCYC, "R6", "busy length", 64'(cyc), 64'(FCYC));
    chk(cyc * TCLK <= 64000, "R6", "within 64us", 64'(cyc * TCLK), 64'd64000);
    check_frame(op, port, dev, payload);
  endtask

  // op, port, dev, reg, write data, PHY read value
  localparam logic [59:0] VEC [4] = '{
    {2'b01, 5'd3,  5'd1,  16'h0000, 16'hA5C3, 16'h0000},
    {2'b11, 5'd31, 5'd30, 16'hFFFF, 16'h1234, 16'hBEEF},
    {2'b01, 5'd0,  5'd0,  16'h8001, 16'h0000, 16'h0000},
    {2'b11, 5'd17, 5'd4,  16'h0020, 16'h7E81, 16'h8001}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cyc;
    logic [31:0] snap;
    longint t0;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_rdata == 32'h0, "R1", "cmd reset", 64'(cmd_rdata), 64'd0);
    chk(dat_rdata == 32'h0, "R1", "data reset", 64'(dat_rdata), 64'd0);
    chk({mdc, mdio_oe, mdio_out} == 3'b001, "R1", "bus reset",
        64'({mdc, mdio_oe, mdio_out}), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) begin
      logic [1:0] op; logic [4:0] pt, dv; logic [15:0] ra, wd, rv;
      {op, pt, dv, ra, wd, rv} = VEC[i];
      phy_rd = rv;
      load_data(wd);
      run_frame(2'b00, pt, dv, ra, ra);
      chk(dat_rdata[31:16] == last_rd, "R9", "rd held after addr", 64'(dat_rdata[31:16]), 64'(last_rd));
      run_frame(op, pt, dv, ra, (op == 2'b01) ? wd : 16'h0);
      if (op == 2'b11) last_rd = rv;
      chk(dat_rdata[31:16] == last_rd, "R5", "read result / R9 hold", 64'(dat_rdata[31:16]), 64'(last_rd));
      chk(dat_rdata[15:0] == wd, "R5", "lower half kept", 64'(dat_rdata[15:0]), 64'(wd));
    end

    // R4 MDC phase widths
    cnt = 0;
    host_cmd(2'b00, 5'd7, 5'd7, 16'h5555, 1'b1);
    @(posedge mdc); t0 = $time;
    @(negedge mdc);
    chk(($time - t0) == HALF * TCLK, "R4", "mdc high", 64'($time - t0), 64'(HALF * TCLK));
    @(posedge mdc);
    chk(($time - t0) == 2 * HALF * TCLK, "R4", "mdc period", 64'($time - t0), 64'(2 * HALF * TCLK));
    @(negedge clk);
    wait_idle(cyc);
    check_frame(2'b00, 5'd7, 5'd7, 16'h5555);

    // R7 command during a frame
    cnt = 0;
    host_cmd(2'b00, 5'd9, 5'd2, 16'h0F0F, 1'b1);
    repeat (40) @(negedge clk);
    host_cmd(2'b11, 5'd1, 5'd1, 16'h1111, 1'b1);
    chk(cmd_rdata[27:0] == {2'b00, 5'd9, 5'd2, 16'h0F0F}, "R7", "cmd while busy",
        64'(cmd_rdata[27:0]), 64'({2'b00, 5'd9, 5'd2, 16'h0F0F}));
    wait_idle(cyc);
    check_frame(2'b00, 5'd9, 5'd2, 16'h0F0F);
    repeat (20) @(negedge clk);
    chk(cnt == 64 && !cmd_rdata[30], "R7", "no second frame", 64'(cnt), 64'd64);

    // R8 reserved opcode and missing go bit
    snap = cmd_rdata; cnt = 0;
    host_cmd(2'b10, 5'd5, 5'd5, 16'hAAAA, 1'b1);
    repeat (10) @(negedge clk);
    chk(cmd_rdata == snap, "R8", "rsvd op ignored", 64'(cmd_rdata), 64'(snap));
    chk(cnt == 0 && !mdc, "R8", "rsvd op no frame", 64'(cnt), 64'd0);
    host_cmd(2'b01, 5'd6, 5'd6, 16'hCCCC, 1'b0);
    repeat (10) @(negedge clk);
    chk(cmd_rdata == snap, "R8", "go=0 ignored", 64'(cmd_rdata), 64'(snap));
    chk(cnt == 0 && !mdc, "R8", "go=0 no frame", 64'(cnt), 64'd0);

    finish_run();
  end
endmodule